// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Combiner

A multistage pipelined converter resolves each sample a few bits at a time. Every stage hands its coarse decision to digital logic one clock after the stage before it did. This block gathers those decisions and produces the finished output word. The decisions are a 4-bit code from the front stage, eight ternary codes from the middle stages, and a 3-bit code from the closing flash quantizer. Because each stage decides one clock later than its predecessor, the block holds every code in a per-stage delay line. The delay lines are sized so that all ten codes of one sample come out in the same cycle.

The aligned codes are added with weights that step by a factor of two from stage to stage. Each stage code overlaps its neighbour by one bit, so a comparator decision that lands slightly wrong in one stage is absorbed by the next stage's code. A fixed offset then takes out the mid-scale bias of the ternary codes. Sums above the 14-bit full scale or below zero are clamped, and the out-of-range flag is raised with that word. The analog stages are not part of this block: their codes arrive on input ports.

Top module: `code_combiner`

## Requirements
- R1: For the sample taken at edge s, the front code is captured at edge s+1. Middle code j (j = 0 nearest the front, bits 2j+1:2j of `mid_codes`) is captured at edge s+2+j. The flash code is captured at edge s+10. All ten codes are combined as one sample.
- R2: The raw value is front·1024 + Σj midj·2^(9−j) + flash − 1020, where a middle code 00/01/10 counts as 0/1/2. When the raw value lies in 0..16383, `result` equals it and `out_of_range` is 0.
- R3: A middle code of 11 is treated exactly like 10.
- R4: A raw value above 16383 gives `result` = 16383 with `out_of_range` = 1.
- R5: A raw value below 0 gives `result` = 0 with `out_of_range` = 1.
- R6: `out_of_range` belongs to each word individually. It stays high across consecutive out-of-range samples and drops with the first in-range word.
- R7: The word for the sample taken at edge s appears on the outputs just after edge s+12.
- R8: While `rst` is sampled high, all delay lines and output registers clear. After a reset edge, `result` = 0, `out_of_range` = 0 and `result_valid` = 0.
- R9: `result_valid` stays 0 for the first 11 edges after reset is released. It is 1 from the 12th edge on and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| first_code | input | 4 | Front-stage code, one sample old |
| mid_codes | input | 16 | Eight ternary stage codes, two bits each |
| flash_code | input | 3 | Closing flash code |
| result | output | 14 | Corrected output word |
| out_of_range | output | 1 | Word was clamped at a range limit |
| result_valid | output | 1 | Pipeline has filled since reset |

## Verification
The hardest situation to reach is a set of words that sit exactly on the clamp limits. Examples are a raw sum of 16383 against 16384, or 0 against −1, and these occur only when all ten codes of one sample hold extreme values. Because the codes of one sample are spread over ten different cycles, the stimulus builds each sample as a complete record first. A driver then interleaves the records, so that each cycle carries codes from ten different samples. Directed records sit at the limits, and illegal 11 codes appear in some of them. Back-to-back out-of-range records check that the flag follows each word individually. A second reset in the middle of the run checks that the pipeline fills again.

// File: rtl/code_comb_pkg.sv
`timescale 1ns/1ps
package code_comb_pkg;

    // Ternary decision of a middle stage
    typedef enum logic [1:0] {
        TRI_LOW  = 2'b00,
        TRI_ZERO = 2'b01,
        TRI_HIGH = 2'b10,
        TRI_BAD  = 2'b11
    } tri_code_e;

    // Illegal pattern folds onto the high decision
    function automatic logic [1:0] tri_value(input logic [1:0] raw);
        logic [1:0] v;
        v = raw;
        if (raw == TRI_BAD) begin
            v = TRI_HIGH;
        end
        return v;
    endfunction

    // Binary exponent of the weight of middle stage idx (0 = nearest front)
    function automatic int tri_weight_exp(input int idx, input int n_mid, input int flash_w);
        return flash_w - 1 + n_mid - 1 - idx;
    endfunction

endpackage

// File: rtl/code_delay_line.sv
`timescale 1ns/1ps
module code_delay_line #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] tap;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tap[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.tap[i] = st_q.tap[i-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.tap[DEPTH-1];
endmodule

// File: rtl/code_weight_sum.sv
`timescale 1ns/1ps
module code_weight_sum
    import code_comb_pkg::*;
#(
    parameter int N_MID   = 8,
    parameter int FIRST_W = 4,
    parameter int FLASH_W = 3,
    parameter int SUM_W   = 16
) (
    input  logic        [FIRST_W-1:0] first_al,
    input  logic        [2*N_MID-1:0] mid_al,
    input  logic        [FLASH_W-1:0] flash_al,
    output logic signed [SUM_W-1:0]   sum
);
    localparam int FIRST_SHIFT = FLASH_W - 1 + N_MID;
    // Mid-scale bias: every ternary stage at its zero decision
    localparam int MID_OFS     = (2 ** (FLASH_W - 1)) * ((2 ** N_MID) - 1);

    logic [SUM_W-1:0] acc;

    always_comb begin
        acc = SUM_W'(first_al) << FIRST_SHIFT;
        acc = acc + SUM_W'(flash_al);
        for (int j = 0; j < N_MID; j++) begin
            acc = acc + (SUM_W'(tri_value(mid_al[2*j +: 2])) << tri_weight_exp(j, N_MID, FLASH_W));
        end
        sum = $signed(acc - SUM_W'(MID_OFS));
    end
endmodule

// File: rtl/code_range_clamp.sv
`timescale 1ns/1ps
module code_range_clamp #(
    parameter int OUT_W = 14,
    parameter int SUM_W = 16
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic        [OUT_W-1:0] code,
    output logic                    over,
    output logic                    under
);
    localparam logic signed [SUM_W-1:0] TOP_CODE = SUM_W'((2 ** OUT_W) - 1);

    always_comb begin
        over  = (sum > TOP_CODE);
        under = sum[SUM_W-1];
        if (over) begin
            code = '1;
        end else if (under) begin
            code = '0;
        end else begin
            code = sum[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/code_combiner.sv
`timescale 1ns/1ps
module code_combiner
    import code_comb_pkg::*;
#(
    parameter  int N_MID   = 8,
    parameter  int FIRST_W = 4,
    parameter  int FLASH_W = 3,
    localparam int OUT_W   = FIRST_W + N_MID + FLASH_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIRST_W-1:0] first_code,
    input  logic [2*N_MID-1:0] mid_codes,
    input  logic [FLASH_W-1:0] flash_code,
    output logic [OUT_W-1:0]   result,
    output logic               out_of_range,
    output logic               result_valid
);
    localparam int NSTG  = N_MID + 2;        // stages feeding the block
    localparam int LAT   = NSTG + 2;         // sampling edge to output edge
    localparam int SUM_W = OUT_W + 2;
    localparam int CNT_W = $clog2(LAT + 1);

    // Aligned codes of one sample
    logic [FIRST_W-1:0]      first_al;
    logic [2*N_MID-1:0]      mid_al;
    logic [FLASH_W-1:0]      flash_al;
    logic signed [SUM_W-1:0] sum_c;
    logic [OUT_W-1:0]        clamp_code;
    logic                    clamp_over;
    logic                    clamp_under;

    typedef struct packed {
        logic signed [SUM_W-1:0] sum;
        logic [OUT_W-1:0]        code;
        logic                    oor;
        logic [CNT_W-1:0]        fill;
    } state_t;

    state_t st_d, st_q;

    // Front stage waits longest, flash stage one register
    code_delay_line #(.W(FIRST_W), .DEPTH(NSTG)) first_line_i (
        .clk (clk), .rst (rst), .din (first_code), .dout (first_al)
    );

    for (genvar j = 0; j < N_MID; j++) begin : g_mid_line
        code_delay_line #(.W(2), .DEPTH(NSTG - 1 - j)) mid_line_i (
            .clk  (clk),
            .rst  (rst),
            .din  (mid_codes[2*j +: 2]),
            .dout (mid_al[2*j +: 2])
        );
    end

    code_delay_line #(.W(FLASH_W), .DEPTH(1)) flash_line_i (
        .clk (clk), .rst (rst), .din (flash_code), .dout (flash_al)
    );

    code_weight_sum #(
        .N_MID (N_MID), .FIRST_W (FIRST_W), .FLASH_W (FLASH_W), .SUM_W (SUM_W)
    ) sum_i (
        .first_al (first_al), .mid_al (mid_al), .flash_al (flash_al), .sum (sum_c)
    );

    code_range_clamp #(.OUT_W (OUT_W), .SUM_W (SUM_W)) clamp_i (
        .sum (st_q.sum), .code (clamp_code), .over (clamp_over), .under (clamp_under)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sum  = sum_c;
        st_d.code = clamp_code;
        st_d.oor  = clamp_over | clamp_under;
        if (st_q.fill != CNT_W'(LAT)) begin
            st_d.fill = st_q.fill + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign result       = st_q.code;
    assign out_of_range = st_q.oor;
    assign result_valid = (st_q.fill == CNT_W'(LAT));
endmodule

// File: rtl/code_combiner_chk.sv
`timescale 1ns/1ps
module code_combiner_chk #(
    parameter int N_MID   = 8,
    parameter int FIRST_W = 4,
    parameter int FLASH_W = 3
) (
    input logic                             clk,
    input logic                             rst,
    input logic [FIRST_W+N_MID+FLASH_W-2:0] result,
    input logic                             out_of_range,
    input logic                             result_valid
);
    localparam int LAT  = N_MID + 4;
    localparam int CW   = $clog2(LAT + 1);

    // Edges seen since reset release, saturating
    logic [CW-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (seen_q != CW'(LAT)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && !out_of_range && !result_valid));

    assert_quiet_before_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (seen_q < CW'(LAT)) |-> !result_valid);

    assert_valid_after_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (seen_q == CW'(LAT)) |-> result_valid);

    assert_valid_holds_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> result_valid);

    // R5 shares this check: a flagged word sits on one of the two limits
    assert_flag_on_limit_R4: assert property (@(posedge clk) disable iff (rst)
        out_of_range |-> (result == '1 || result == '0));
endmodule

bind code_combiner code_combiner_chk #(
    .N_MID (N_MID), .FIRST_W (FIRST_W), .FLASH_W (FLASH_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .result       (result),
    .out_of_range (out_of_range),
    .result_valid (result_valid)
);

// File: tb/code_combiner_tb_top.sv
`timescale 1ns/1ps
module code_combiner_tb_top;
    localparam int N_MID   = 8;
    localparam int NSTG    = 10;
    localparam int LAT     = 12;
    localparam int NS      = 40;
    localparam int MAXC    = 16383;
    localparam int MID_OFS = 1020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  first_code = '0;
    logic [15:0] mid_codes  = '0;
    logic [2:0]  flash_code = '0;
    logic [13:0] result;
    logic        out_of_range;
    logic        result_valid;

    int checks = 0;
    int fails  = 0;
    int since  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    val;
        bit    oor;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int s_first[NS];
    int s_mid[NS][N_MID];
    int s_flash[NS];

    always #2.5 clk = ~clk;   // 200 MHz

    code_combiner dut_i (
        .clk (clk), .rst (rst), .first_code (first_code), .mid_codes (mid_codes),
        .flash_code (flash_code), .result (result), .out_of_range (out_of_range),
        .result_valid (result_valid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Expected word from the requirement formula (R2 R3 R4 R5)
    function automatic exp_t model(input int n);
        exp_t e;
        int   raw;
        bit   bad;
        raw = s_first[n] * 1024 + s_flash[n] - MID_OFS;
        bad = 1'b0;
        for (int j = 0; j < N_MID; j++) begin
            int m;
            m = s_mid[n][j];
            if (m == 3) begin
                m   = 2;
                bad = 1'b1;
            end
            raw += m << (9 - j);
        end
        if (raw > MAXC) begin
            e.val = MAXC; e.oor = 1'b1; e.tag = "R4 R6";
        end else if (raw < 0) begin
            e.val = 0;    e.oor = 1'b1; e.tag = "R5 R6";
        end else begin
            e.val = raw;  e.oor = 1'b0; e.tag = bad ? "R3 R1 R7" : "R2 R1 R7";
        end
        return e;
    endfunction

    task automatic set_sample(input int n, input int f, input int m, input int fl);
        s_first[n] = f;
        for (int j = 0; j < N_MID; j++) s_mid[n][j] = m;
        s_flash[n] = fl;
    endtask

    task automatic fill_set(input bit directed);
        for (int n = 0; n < NS; n++) begin
            s_first[n] = $urandom_range(15, 0);
            for (int j = 0; j < N_MID; j++) s_mid[n][j] = $urandom_range(3, 0);
            s_flash[n] = $urandom_range(7, 0);
        end
        if (directed) begin
            set_sample(0, 8, 1, 4);            // mid-scale, 8196
            set_sample(1, 15, 2, 7);           // 16387 -> clamp high
            set_sample(2, 15, 2, 3);           // exactly 16383
            set_sample(3, 15, 3, 7);           // illegal codes, still high
            set_sample(4, 0, 1, 3);
            s_mid[4][7] = 0;                   // raw -1 -> clamp low
            set_sample(5, 0, 1, 0);            // exactly 0
            set_sample(6, 0, 0, 0);            // -1020 -> clamp low
            set_sample(7, 4, 1, 2);
            s_mid[7][0] = 3;                   // R3: counts as 10, 4610
            set_sample(8, 4, 1, 2);
            s_mid[8][0] = 2;                   // same word via legal 10
        end
    endtask

    // Driver: each cycle carries codes of ten different samples
    task automatic run_stream(input int n);
        for (int c = 0; c < n + LAT; c++) begin
            first_code = (c < n) ? 4'(s_first[c]) : 4'd0;
            for (int j = 0; j < N_MID; j++) begin
                int idx;
                idx = c - 1 - j;
                mid_codes[2*j +: 2] = (idx >= 0 && idx < n) ? 2'(s_mid[idx][j]) : 2'b00;
            end
            flash_code = (c - (NSTG - 1) >= 0 && c - (NSTG - 1) < n) ?
                         3'(s_flash[c - (NSTG - 1)]) : 3'd0;
            if (c < n) sb_q.push_back(model(c));
            if (c == 0) rst = 1'b0;
            @(negedge clk);
        end
    endtask

    // Monitor: samples 1 ns after each rising edge
    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                since = 0;
                check(result == 0 && !out_of_range && !result_valid, "R8",
                      "reset state", {result, out_of_range, result_valid}, 0);
            end else begin
                since++;
                if (since == LAT - 1) check(!result_valid, "R9", "valid early", result_valid, 0);
                if (since == LAT)     check(result_valid, "R9", "valid on time", result_valid, 1);
                if (result_valid && sb_q.size() > 0) begin
                    e = sb_q.pop_front();
                    check(int'(result) == e.val, e.tag, "result", result, e.val);
                    check(out_of_range == e.oor, e.tag, "out_of_range", out_of_range, e.oor);
                end
            end
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        fill_set(1'b1);
        run_stream(NS);
        check(sb_q.size() == 0, "R7", "words left", sb_q.size(), 0);
        rst = 1'b1;                      // second reset mid-run (R8 R9)
        repeat (2) @(negedge clk);
        fill_set(1'b0);
        run_stream(NS);
        check(sb_q.size() == 0, "R7", "words left", sb_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : watchdog
        #1000000ns;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule